// File: doc/BRIEF.md
# Receive Lane Bridge with Idle-Based Clock Compensation

This block sits between a SERDES receive path and an 8-bit physical coding sublayer. On the recovered-clock side it accepts 40-bit words. Each word carries four decoded characters, and each character has its own control flag and code-violation flag. On the system-clock side it delivers one character per cycle with both flags attached. The two clocks are unrelated, so words cross through a Gray-pointer asynchronous FIFO. In the system-clock domain a small controller splits each word into its byte lanes.

The two clocks may differ by a small frequency offset. The controller corrects for it by watching the FIFO fill level. When the fill is high, it drops a whole idle ordered set (K28.5 followed by a data character). When the fill is low, it sends an idle ordered set a second time. It only does this where a word begins with an idle set, so packet contents are never changed and an idle set is never split. If the FIFO overflows or runs dry, a sticky error flag is set. From then on every delivered byte is marked as a code violation until reset.

Back-pressure rules: `in_ready` is low while the FIFO is full. A word offered with `in_valid` high while `in_ready` is low is lost, and this counts as an overflow. The receive line cannot be stalled, so the source is expected never to hit this case. The output side has no ready: the consumer must take every byte for which `out_valid` is high.

Top module: `rx_lane_elastic_bridge`

## Requirements
- R1: Each input lane is 10 bits: bit 9 is the code-violation flag, bit 8 the control flag and bits 7:0 the character. Lane n occupies bits 10n+9:10n, and lanes are emitted in order 0, 1, 2, 3, each with its own flags on `out_cv`/`out_k`.
- R2: Every character that is not part of an idle set reaches the output unchanged and in input order, across unrelated clocks.
- R3: `in_ready` is high after reset and goes low while the FIFO holds DEPTH words.
- R4: After reset, `out_valid` and `err_flag` are low, and no byte is delivered until the FIFO has held at least DEPTH/2 words.
- R5: An idle set is a lane 0 character 8'hBC with control flag 1 and no violation, followed in lane 1 by a character with control flag 0 and no violation. When the fill level is at or above HI_MARK and a word begins with an idle set, both characters of that set are dropped.
- R6: When the fill level is at or below LO_MARK and a word begins with an idle set, that set is delivered twice in a row.
- R7: Adjustment happens at most once per word, only on an idle set at the start of a word, and never splits a set. An emitted 8'hBC control character is always followed directly by its data partner.
- R8: An offered word that is refused while full (overflow), or a needed word that is missing once output has started (underflow), sets `err_flag`. With no such event, `err_flag` stays low.
- R9: Once `err_flag` is set it stays set until reset, and every byte delivered while it is set has `out_cv` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rec_clk | input | 1 | Recovered clock of the SERDES side |
| sys_clk | input | 1 | System clock of the byte side |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| in_word | input | 40 | Four 10-bit lanes {cv, k, char[7:0]} |
| in_valid | input | 1 | A word is offered on `in_word` |
| in_ready | output | 1 | FIFO can take a word (recovered-clock domain) |
| out_valid | output | 1 | A character is present on the byte outputs |
| out_data | output | 8 | Delivered character |
| out_k | output | 1 | Control flag of the delivered character |
| out_cv | output | 1 | Code-violation flag, forced high while `err_flag` is set |
| err_flag | output | 1 | Sticky overflow/underflow indication (system-clock domain) |

## Verification
The bench runs the recovered clock at the nominal ratio, faster and slower. It tracks idle sets separately from packet bytes, so a design that adjusts with no drift, adjusts the wrong way, or corrupts a packet byte shows up as a wrong idle balance or a payload mismatch. A design that splits an idle set leaves an 8'hBC control character without its data partner, which the monitor flags. The bench forces a dry FIFO and a flood of words. A design that misses underflow or overflow, clears the flag when traffic resumes, or lets clean bytes through after an error is caught. A design that starts output before the half-full point is also caught.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int LANE_W = 10;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
  localparam logic [7:0] COMMA_CHAR = 8'hBC;

  typedef struct packed {
    logic       cv;
    logic       k;
    logic [7:0] d;
  } lane_t;

  // true when lanes a,b form an idle ordered set
  function automatic logic idle_pair(input lane_t a, input lane_t b);
    return a.k && !a.cv && (a.d == COMMA_CHAR) && !b.k && !b.cv;
  endfunction
endpackage

// File: rtl/rxb_sync2.sv
module rxb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rxb_async_fifo.sv
module rxb_async_fifo #(
  parameter int W  = 40,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  output logic          full,
  input  logic          rd_en,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic [AW:0]   rd_fill
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin, wgray, rbin, rgray;
  logic [AW:0]  wgray_s, rgray_s;
  logic         do_wr, do_rd;

  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // write domain
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (do_wr) begin
      wbin  <= wbin + 1'b1;
      wgray <= to_gray(wbin + 1'b1);
    end
  end

  always_ff @(posedge wclk) begin
    if (do_wr) mem[wbin[AW-1:0]] <= wdata;
  end

  rxb_sync2 #(.W(AW + 1)) u_rptr_sync (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  assign full = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});

  // read domain
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (do_rd) begin
      rbin  <= rbin + 1'b1;
      rgray <= to_gray(rbin + 1'b1);
    end
  end

  rxb_sync2 #(.W(AW + 1)) u_wptr_sync (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  assign empty   = (rgray == wgray_s);
  assign rdata   = mem[rbin[AW-1:0]];
  assign rd_fill = from_gray(wgray_s) - rbin;

  // Gray pointers move by at most one bit per edge (crossing safety behind R2)
  p_wgray_step_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  p_rgray_step_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  // fill seen by the reader never exceeds capacity
  p_fill_bound_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_fill <= (AW + 1)'(DEPTH));
endmodule

// File: rtl/rxb_elastic_unpack.sv
module rxb_elastic_unpack
  import rxb_pkg::*;
#(
  parameter int AW      = 4,
  parameter int HI_MARK = 12,
  parameter int LO_MARK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              empty,
  input  logic [AW:0]       fill,
  input  logic              ovf_in,
  output logic              pop,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_k,
  output logic              out_cv,
  output logic              err
);
  localparam logic [AW:0] START_L = (AW + 1)'((1 << AW) / 2);
  localparam logic [AW:0] HI_L    = (AW + 1)'(HI_MARK);
  localparam logic [AW:0] LO_L    = (AW + 1)'(LO_MARK);

  logic [WORD_W-1:0] cur;
  logic              cur_vld, started, rep_pend, adj_done;
  logic [1:0]        idx;
  lane_t             lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = lane_t'(cur[g*LANE_W +: LANE_W]);
  end

  logic       head_idle, emit, uflow, err_nx;
  logic [1:0] sel, n_idx;
  logic       n_vld, n_rep, n_adj;
  lane_t      ln;

  assign head_idle = idle_pair(lanes[0], lanes[1]);

  always_comb begin
    pop   = 1'b0;
    emit  = 1'b0;
    uflow = 1'b0;
    sel   = idx;
    n_idx = idx;
    n_vld = cur_vld;
    n_rep = rep_pend;
    n_adj = adj_done;
    if (started) begin
      if (!cur_vld) begin
        if (!empty) begin
          pop   = 1'b1;
          n_vld = 1'b1;
          n_idx = 2'd0;
          n_adj = 1'b0;
        end else begin
          uflow = 1'b1;
        end
      end else begin
        emit = 1'b1;
        if (idx == 2'd0 && head_idle && !adj_done && fill >= HI_L) begin
          sel   = 2'd2;          // skip the idle set in lanes 0,1
          n_idx = 2'd3;
          n_adj = 1'b1;
        end else if (idx == 2'd0 && head_idle && !adj_done && fill <= LO_L) begin
          n_idx = 2'd1;          // lanes 0,1 will be sent twice
          n_rep = 1'b1;
          n_adj = 1'b1;
        end else if (idx == 2'd1 && rep_pend) begin
          n_idx = 2'd0;
          n_rep = 1'b0;
        end else if (idx == 2'd3) begin
          if (!empty) begin
            pop   = 1'b1;
            n_idx = 2'd0;
            n_adj = 1'b0;
          end else begin
            n_vld = 1'b0;
            uflow = 1'b1;
          end
        end else begin
          n_idx = idx + 2'd1;
        end
      end
    end
  end

  assign ln     = lanes[sel];
  assign err_nx = err | uflow | ovf_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= '0;
      cur_vld   <= 1'b0;
      started   <= 1'b0;
      rep_pend  <= 1'b0;
      adj_done  <= 1'b0;
      idx       <= 2'd0;
      err       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_k     <= 1'b0;
      out_cv    <= 1'b0;
    end else begin
      if (!started && fill >= START_L) started <= 1'b1;
      if (pop) cur <= word;
      cur_vld   <= n_vld;
      rep_pend  <= n_rep;
      adj_done  <= n_adj;
      idx       <= n_idx;
      err       <= err_nx;
      out_valid <= emit;
      out_data  <= ln.d;
      out_k     <= ln.k;
      out_cv    <= ln.cv | err_nx;
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_err_marks_cv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && out_valid) |-> out_cv);
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_hold_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !pop);
endmodule

// File: rtl/rx_lane_elastic_bridge.sv
module rx_lane_elastic_bridge
  import rxb_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4,
  parameter int HI_MARK    = 12,
  parameter int LO_MARK    = 4
) (
  input  logic              rec_clk,
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_k,
  output logic              out_cv,
  output logic              err_flag
);
  logic              full, empty, pop, ovf_w, ovf_s;
  logic [WORD_W-1:0] head;
  logic [DEPTH_LOG2:0] fill;

  assign in_ready = !full;

  always_ff @(posedge rec_clk or negedge rst_n) begin
    if (!rst_n)                   ovf_w <= 1'b0;
    else if (in_valid && full)    ovf_w <= 1'b1;
  end

  rxb_async_fifo #(.W(WORD_W), .AW(DEPTH_LOG2)) u_fifo (
    .wclk(rec_clk), .rclk(sys_clk), .rst_n(rst_n),
    .wr_en(in_valid), .wdata(in_word), .full(full),
    .rd_en(pop), .rdata(head), .empty(empty), .rd_fill(fill)
  );

  rxb_sync2 #(.W(1)) u_ovf_sync (
    .clk(sys_clk), .rst_n(rst_n), .d(ovf_w), .q(ovf_s)
  );

  rxb_elastic_unpack #(.AW(DEPTH_LOG2), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_unpack (
    .clk(sys_clk), .rst_n(rst_n), .word(head), .empty(empty), .fill(fill),
    .ovf_in(ovf_s), .pop(pop), .out_valid(out_valid), .out_data(out_data),
    .out_k(out_k), .out_cv(out_cv), .err(err_flag)
  );

  p_ovf_sticky_r8: assert property (@(posedge rec_clk) disable iff (!rst_n)
    ovf_w |=> ovf_w);
endmodule

// File: tb/tb_rx_lane_elastic_bridge.sv
`timescale 1ns/1ps
module tb_rx_lane_elastic_bridge;
  localparam int DEPTH = 16;
  localparam logic [9:0] IDL_A = 10'h1BC;
  localparam logic [9:0] IDL_B = 10'h050;

  logic        rec_clk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
  logic [39:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, out_valid, out_k, out_cv, err_flag;
  logic [7:0]  out_data;
  real         wper = 40.0;

  rx_lane_elastic_bridge dut (
    .rec_clk(rec_clk), .sys_clk(sys_clk), .rst_n(rst_n),
    .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_k(out_k),
    .out_cv(out_cv), .err_flag(err_flag)
  );

  always #5 sys_clk = ~sys_clk;
  always #(wper / 2.0) rec_clk = ~rec_clk;

  typedef struct { logic [7:0] d; logic k; logic cv; int idles; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, mode = 0, cyc = 0;
  int in_idles = 0, out_idles = 0, last_diff = 0, accepted = 0;
  int early_out = 0, err_bytes = 0;
  bit skip_next = 0, saw_not_ready = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge sys_clk) begin
    if (rst_n && out_valid) begin
      if (accepted < DEPTH / 2) early_out++;
      if (mode == 2) begin
        err_bytes++;
        chk(out_cv, "R9", "cv forced after error", out_cv, 1);
      end else if (mode == 1) begin
        if (skip_next) begin
          skip_next = 0;
          chk(!out_k && !out_cv, "R7", "idle partner follows comma", {out_k, out_cv}, 0);
        end else if (out_k && !out_cv && out_data == 8'hBC) begin
          skip_next = 1;
          out_idles++;
        end else if (q.size() == 0) begin
          chk(0, "R2", "unexpected byte", out_data, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_data == e.d && out_k == e.k && out_cv == e.cv, "R1,R2", "byte {cv,k,d}",
              {out_cv, out_k, out_data}, {e.cv, e.k, e.d});
          last_diff = out_idles - e.idles;
        end
      end
    end
  end

  // watchdog
  always @(posedge sys_clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d expected < %0d cycles", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver: waits for ready, pushes expected characters on acceptance
  task automatic put_word(input logic [39:0] w, input bit idle);
    @(negedge rec_clk);
    in_word  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge rec_clk);
    @(posedge rec_clk);
    accepted++;
    if (idle) in_idles += 2;
    else begin
      for (int i = 0; i < 4; i++) begin
        exp_t e;
        e.d = w[i*10 +: 8]; e.k = w[i*10 + 8]; e.cv = w[i*10 + 9]; e.idles = in_idles;
        q.push_back(e);
      end
    end
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) put_word({IDL_B, IDL_A, IDL_B, IDL_A}, 1'b1);
  endtask

  task automatic packet(input int nw, input bit with_cv);
    for (int i = 0; i < nw; i++) begin
      logic [39:0] w;
      for (int l = 0; l < 4; l++) w[l*10 +: 10] = {2'b00, 8'($urandom)};
      if (i == 0) w[9:0] = 10'h1FB;
      if (i == nw - 1) w[39:30] = 10'h1FD;
      if (with_cv && i == 1) w[29] = 1'b1;
      put_word(w, 1'b0);
    end
  endtask

  task automatic reset_dut(input real per);
    mode = 0;
    in_valid = 1'b0;
    rst_n = 1'b0;
    wper = per;
    repeat (6) @(negedge sys_clk);
    q.delete();
    in_idles = 0; out_idles = 0; last_diff = 0; accepted = 0;
    early_out = 0; err_bytes = 0; skip_next = 0; saw_not_ready = 0;
    rst_n = 1'b1;
  endtask

  task automatic stream_phase(input int npk);
    mode = 1;
    idles(8);
    for (int p = 0; p < npk; p++) begin
      packet(5, p % 7 == 3);
      idles(4 + (p % 3));
    end
    idles(40);
    mode = 0;
  endtask

  initial begin
    reset_dut(40.0);
    @(negedge sys_clk);
    chk(!out_valid, "R4", "out_valid after reset", out_valid, 0);
    chk(!err_flag, "R4", "err_flag after reset", err_flag, 0);
    chk(in_ready, "R3", "in_ready after reset", in_ready, 1);

    // matched clocks: no adjustment expected
    stream_phase(30);
    chk(q.size() == 0, "R2", "all payload delivered (nominal)", q.size(), 0);
    chk(last_diff == 0, "R5,R6", "idle balance with no drift", last_diff, 0);
    chk(!err_flag, "R8", "no error at nominal rate", err_flag, 0);
    chk(early_out == 0, "R4", "no output before half full", early_out, 0);

    // fast recovered clock: deletions expected
    reset_dut(38.0);
    stream_phase(40);
    chk(q.size() == 0, "R2", "all payload delivered (fast)", q.size(), 0);
    chk(last_diff < 0, "R5", "idle sets removed when filling", last_diff, -1);
    chk(!err_flag, "R8", "no error when writer fast", err_flag, 0);

    // slow recovered clock: insertions expected
    reset_dut(42.0);
    stream_phase(40);
    chk(q.size() == 0, "R2", "all payload delivered (slow)", q.size(), 0);
    chk(last_diff > 0, "R6", "idle sets repeated when draining", last_diff, 1);
    chk(!err_flag, "R8", "no error when writer slow", err_flag, 0);
    chk(early_out == 0, "R4", "no output before half full (slow)", early_out, 0);

    // underflow: starve the FIFO, then resume
    reset_dut(40.0);
    mode = 1;
    idles(10);
    packet(4, 1'b0);
    idles(2);
    mode = 0;
    in_valid = 1'b0;
    repeat (100) @(negedge sys_clk);
    chk(err_flag, "R8", "underflow sets error", err_flag, 1);
    mode = 2;
    idles(12);
    packet(4, 1'b0);
    idles(4);
    in_valid = 1'b0;
    repeat (60) @(negedge sys_clk);
    mode = 0;
    chk(err_bytes > 0, "R9", "bytes delivered after error", err_bytes, 1);
    chk(err_flag, "R9", "error stays set after traffic resumes", err_flag, 1);

    // overflow: flood with data words at four times the drain rate
    reset_dut(10.0);
    for (int i = 0; i < 48; i++) begin
      @(negedge rec_clk);
      if (!in_ready) saw_not_ready = 1;
      in_word = {10'h033, 10'h022, 10'h011, 10'h000};
      in_valid = 1'b1;
    end
    @(negedge rec_clk);
    in_valid = 1'b0;
    chk(saw_not_ready, "R3", "in_ready drops when full", saw_not_ready, 1);
    repeat (10) @(negedge sys_clk);
    chk(err_flag, "R8", "overflow sets error", err_flag, 1);

    reset_dut(40.0);
    @(negedge sys_clk);
    chk(!err_flag, "R4", "reset clears error", err_flag, 0);
    chk(!out_valid, "R4", "no output right after reset", out_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule